// File: doc/BRIEF.md
# Four-Channel Memory Copy Engine

This block moves data between two addresses in a shared memory on behalf of up to four channels. A separate control block owns each channel's programmed control word, source address and destination address. The control block pulses a load strobe to copy them into the engine's working registers, and pulses an arm strobe when the channel's start event fires. The engine then services every armed channel in a fixed order. For each unit it issues one read and one write on a simple valid/ready memory port. It steps the working addresses as the control fields select, and on completion it either reloads the channel for another round or ends it.

A FIFO-feed start mode serves a consumer that raises a half-empty flag. In that mode a single service moves a bounded burst of units. The channel re-arms itself while the flag is still high and counts as finished only once its remaining count has drained. Completion can raise a one-cycle interrupt pulse per channel. A separate one-cycle end pulse tells the control block to drop the channel's enable bit.

Top module: `dma_xfer_engine`

## Requirements
- R1: After a synchronous reset, `busy`, `mem_valid`, `irq_o` and `end_o` are all low.
- R2: Each unit is one read at the working source address followed by one write at the working destination address. `mem_word` equals control bit 26 (1 = 32-bit, 0 = 16-bit). The written data is the read data, with the upper 16 bits forced to zero for 16-bit units.
- R3: The source control field (bits 24:23) increments for 0, decrements for 1 and holds the address for 2 or 3. The step is 4 for 32-bit units and 2 for 16-bit units.
- R4: The destination control field (bits 22:21) increments for 0 or 3, decrements for 1 and holds the address for 2, with the same step sizes.
- R5: Working addresses are 28 bits wide and wrap modulo 2^28 in both directions.
- R6: Armed channels are serviced in ascending index order, and a channel's armed flag clears when its service starts. An arm strobe is ignored while the channel's enable bit (31) is 0.
- R7: In start mode 7 (bits 29:27), one service moves at most 112 units and the count keeps the remainder. The channel re-arms itself if `fifo_half_empty` is high when the service ends. While units remain, it raises neither interrupt nor end pulse.
- R8: On completion with the repeat bit (25) set and a nonzero start mode, the count reloads from bits 20:0 and no end pulse is raised. When the destination control is 3, the destination also reloads from the programmed value. The channel then waits for its next arm.
- R9: On completion without repeat, or in start mode 0, `end_o[ch]` pulses for one cycle and the channel stays unarmed.
- R10: On completion with bit 30 set, `irq_o[ch]` pulses for one cycle. At most one interrupt bit is high at a time.
- R11: `mem_valid` holds with a stable address and direction until `mem_ready` is high. Read data is taken on `mem_rdata` one cycle after the read handshake.
- R12: A service that starts with a count of zero makes no memory access and completes at once.
- R13: A load strobe copies the programmed source, destination and count field into the channel's working registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_word | input | NCH*32 | Programmed control word per channel |
| prog_src | input | NCH*AW | Programmed source address per channel |
| prog_dst | input | NCH*AW | Programmed destination address per channel |
| load_i | input | NCH | Copy programmed values into working registers |
| arm_i | input | NCH | Start event per channel |
| fifo_half_empty | input | 1 | Consumer FIFO is at most half full |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_word | output | 1 | 1 = 32-bit unit, 0 = 16-bit unit |
| mem_addr | output | AW | Request address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after read handshake |
| busy | output | 1 | A channel is being serviced |
| irq_o | output | NCH | Completion interrupt pulses |
| end_o | output | NCH | Channel-ended pulses |

## Verification
An arm strobe sampled at one edge is picked at the next edge, and the read request goes out one edge after that. The write request follows one cycle after the read data returns. The interrupt and end pulses appear two edges after the last write handshake, in the same cycle `busy` drops. Because `mem_ready` stalls on a fixed pattern, the bench does not predict absolute cycles. A monitor compares every accepted write, at the falling edge, against a queue of expected address, data and size. Pulse counts are compared only after `busy` and `mem_valid` have both stayed low for several cycles, so every due result has settled.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;
  localparam int CW     = 21;
  localparam int DW     = 32;
  localparam int B_DCTL = 21;
  localparam int B_SCTL = 23;
  localparam int B_RPT  = 25;
  localparam int B_WORD = 26;
  localparam int B_MODE = 27;
  localparam int B_IE   = 30;
  localparam int B_EN   = 31;
  localparam logic [2:0] MODE_NOW  = 3'd0;
  localparam logic [2:0] MODE_FEED = 3'd7;
  localparam logic [1:0] DCTL_RELOAD = 2'd3;

  typedef enum logic [2:0] {
    S_IDLE, S_LOOP, S_RD, S_RWAIT, S_WR, S_FIN
  } seq_state_t;
endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
  parameter int AW = 28,
  parameter bit IS_DST = 1'b0
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    ctl,
  input  logic          word,
  output logic [AW-1:0] nxt
);
  logic [AW-1:0] step;
  logic          up;
  logic          down;

  always_comb begin
    step = word ? AW'(4) : AW'(2);
    if (IS_DST) up = (ctl == 2'd0) || (ctl == 2'd3);
    else        up = (ctl == 2'd0);
    down = (ctl == 2'd1);
    if (up)        nxt = addr + step;
    else if (down) nxt = addr - step;
    else           nxt = addr;
  end
endmodule

// File: rtl/dma_pick.sv
module dma_pick #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    gnt = '0;
    idx = '0;
    any = |req;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        idx    = IW'(i);
      end
    end
  end

  always_comb begin
    if (|req) begin
      a_r6_grant_onehot: assert ($onehot(gnt) && ((gnt & req) != '0));
    end
  end
endmodule

// File: rtl/dma_chan_bank.sv
module dma_chan_bank #(
  parameter int NCH = 4,
  parameter int AW  = 28,
  parameter int CW  = 21,
  parameter int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    load,
  input  logic [NCH*AW-1:0] ld_src,
  input  logic [NCH*AW-1:0] ld_dst,
  input  logic [NCH*CW-1:0] ld_cnt,
  input  logic              wb_en,
  input  logic [CHW-1:0]    wb_ch,
  input  logic [AW-1:0]     wb_src,
  input  logic [AW-1:0]     wb_dst,
  input  logic [CW-1:0]     wb_cnt,
  output logic [NCH*AW-1:0] src_q,
  output logic [NCH*AW-1:0] dst_q,
  output logic [NCH*CW-1:0] cnt_q
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [AW-1:0] src_r;
    logic [AW-1:0] dst_r;
    logic [CW-1:0] cnt_r;
    logic          hit;

    assign hit = wb_en && (wb_ch == CHW'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        src_r <= '0;
        dst_r <= '0;
        cnt_r <= '0;
      end else if (load[g]) begin
        src_r <= ld_src[g*AW +: AW];
        dst_r <= ld_dst[g*AW +: AW];
        cnt_r <= ld_cnt[g*CW +: CW];
      end else if (hit) begin
        src_r <= wb_src;
        dst_r <= wb_dst;
        cnt_r <= wb_cnt;
      end
    end

    assign src_q[g*AW +: AW] = src_r;
    assign dst_q[g*AW +: AW] = dst_r;
    assign cnt_q[g*CW +: CW] = cnt_r;

    a_r13_load_copies: assert property (@(posedge clk) disable iff (rst)
      load[g] |=> (cnt_r == $past(ld_cnt[g*CW +: CW])) && (src_r == $past(ld_src[g*AW +: AW])));
  end
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_eng_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int AW    = 28,
  parameter int BURST = 112
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH*32-1:0] ctl_word,
  input  logic [NCH*AW-1:0] prog_src,
  input  logic [NCH*AW-1:0] prog_dst,
  input  logic [NCH-1:0]    load_i,
  input  logic [NCH-1:0]    arm_i,
  input  logic              fifo_half_empty,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic              mem_word,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  output logic              busy,
  output logic [NCH-1:0]    irq_o,
  output logic [NCH-1:0]    end_o
);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int BW  = $clog2(BURST + 1);

  seq_state_t state_q;

  logic [NCH-1:0]    en_vec;
  logic [NCH*CW-1:0] cnt_field;
  logic [NCH-1:0]    active_q;
  logic [NCH-1:0]    active_nx;
  logic [NCH-1:0]    gnt;
  logic [CHW-1:0]    pick_idx;
  logic              pick_any;

  logic [NCH*AW-1:0] bank_src;
  logic [NCH*AW-1:0] bank_dst;
  logic [NCH*CW-1:0] bank_cnt;

  logic [CHW-1:0] ch_q;
  logic [1:0]     dctl_q;
  logic [1:0]     sctl_q;
  logic           rpt_q;
  logic [2:0]     mode_q;
  logic           ie_q;
  logic [CW-1:0]  rld_cnt_q;
  logic [AW-1:0]  src_q;
  logic [AW-1:0]  dst_q;
  logic [CW-1:0]  cnt_q;
  logic [BW-1:0]  burst_q;
  logic [AW-1:0]  src_nx;
  logic [AW-1:0]  dst_nx;

  logic           feed_mode;
  logic           stop_now;
  logic           done;
  logic           reload;
  logic [AW-1:0]  wb_dst;
  logic [CW-1:0]  wb_cnt;

  for (genvar g = 0; g < NCH; g++) begin : g_dec
    assign en_vec[g]              = ctl_word[g*32 + B_EN];
    assign cnt_field[g*CW +: CW]  = ctl_word[g*32 +: CW];
  end

  dma_pick #(.N(NCH), .IW(CHW)) u_pick (
    .req (active_q),
    .gnt (gnt),
    .idx (pick_idx),
    .any (pick_any)
  );

  dma_addr_step #(.AW(AW), .IS_DST(1'b0)) u_src_step (
    .addr (src_q), .ctl (sctl_q), .word (mem_word), .nxt (src_nx)
  );

  dma_addr_step #(.AW(AW), .IS_DST(1'b1)) u_dst_step (
    .addr (dst_q), .ctl (dctl_q), .word (mem_word), .nxt (dst_nx)
  );

  // completion decisions taken in S_FIN
  always_comb begin
    feed_mode = (mode_q == MODE_FEED);
    stop_now  = (cnt_q == '0) || (feed_mode && (burst_q == BW'(BURST)));
    done      = !(feed_mode && (cnt_q != '0));
    reload    = rpt_q && (mode_q != MODE_NOW);
    wb_cnt    = (done && reload) ? rld_cnt_q : cnt_q;
    wb_dst    = (done && reload && (dctl_q == DCTL_RELOAD)) ? prog_dst[ch_q*AW +: AW] : dst_q;
  end

  dma_chan_bank #(.NCH(NCH), .AW(AW), .CW(CW), .CHW(CHW)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .load   (load_i),
    .ld_src (prog_src),
    .ld_dst (prog_dst),
    .ld_cnt (cnt_field),
    .wb_en  (state_q == S_FIN),
    .wb_ch  (ch_q),
    .wb_src (src_q),
    .wb_dst (wb_dst),
    .wb_cnt (wb_cnt),
    .src_q  (bank_src),
    .dst_q  (bank_dst),
    .cnt_q  (bank_cnt)
  );

  // armed flags
  always_comb begin
    active_nx = active_q | (arm_i & en_vec);
    if (state_q == S_IDLE && pick_any) active_nx = active_nx & ~gnt;
    if (state_q == S_FIN) begin
      if (feed_mode && fifo_half_empty) active_nx[ch_q] = 1'b1;
      if (done && !reload)              active_nx[ch_q] = 1'b0;
    end
    active_nx = active_nx & en_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) active_q <= '0;
    else     active_q <= active_nx;
  end

  // service sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      ch_q      <= '0;
      dctl_q    <= '0;
      sctl_q    <= '0;
      rpt_q     <= 1'b0;
      mode_q    <= '0;
      ie_q      <= 1'b0;
      rld_cnt_q <= '0;
      src_q     <= '0;
      dst_q     <= '0;
      cnt_q     <= '0;
      burst_q   <= '0;
      mem_valid <= 1'b0;
      mem_we    <= 1'b0;
      mem_word  <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      irq_o     <= '0;
      end_o     <= '0;
    end else begin
      irq_o <= '0;
      end_o <= '0;
      case (state_q)
        S_IDLE: begin
          if (pick_any) begin
            ch_q      <= pick_idx;
            dctl_q    <= ctl_word[pick_idx*32 + B_DCTL +: 2];
            sctl_q    <= ctl_word[pick_idx*32 + B_SCTL +: 2];
            rpt_q     <= ctl_word[pick_idx*32 + B_RPT];
            mem_word  <= ctl_word[pick_idx*32 + B_WORD];
            mode_q    <= ctl_word[pick_idx*32 + B_MODE +: 3];
            ie_q      <= ctl_word[pick_idx*32 + B_IE];
            rld_cnt_q <= ctl_word[pick_idx*32 +: CW];
            src_q     <= bank_src[pick_idx*AW +: AW];
            dst_q     <= bank_dst[pick_idx*AW +: AW];
            cnt_q     <= bank_cnt[pick_idx*CW +: CW];
            burst_q   <= '0;
            state_q   <= S_LOOP;
          end
        end
        S_LOOP: begin
          if (stop_now) begin
            state_q <= S_FIN;
          end else begin
            mem_valid <= 1'b1;
            mem_we    <= 1'b0;
            mem_addr  <= src_q;
            state_q   <= S_RD;
          end
        end
        S_RD: begin
          if (mem_ready) begin
            mem_valid <= 1'b0;
            state_q   <= S_RWAIT;
          end
        end
        S_RWAIT: begin
          mem_wdata <= mem_word ? mem_rdata : {16'h0000, mem_rdata[15:0]};
          mem_valid <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= dst_q;
          state_q   <= S_WR;
        end
        S_WR: begin
          if (mem_ready) begin
            mem_valid <= 1'b0;
            src_q     <= src_nx;
            dst_q     <= dst_nx;
            cnt_q     <= cnt_q - CW'(1);
            burst_q   <= burst_q + BW'(1);
            state_q   <= S_LOOP;
          end
        end
        S_FIN: begin
          if (done && ie_q)            irq_o[ch_q] <= 1'b1;
          if (done && !reload)         end_o[ch_q] <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy = (state_q != S_IDLE);

  a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));
  a_r1_idle_no_req: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_valid);
  a_r10_irq_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq_o));
  a_r10_irq_pulse: assert property (@(posedge clk) disable iff (rst)
    (|irq_o) |=> !(|irq_o));
  a_r9_end_pulse: assert property (@(posedge clk) disable iff (rst)
    (|end_o) |=> !(|end_o));
  a_r7_burst_cap: assert property (@(posedge clk) disable iff (rst)
    burst_q <= BW'(BURST));
  a_r12_zero_no_access: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_LOOP && cnt_q == '0) |=> !mem_valid);
endmodule

// File: tb/dma_xfer_engine_test.sv
module dma_xfer_engine_test;
  localparam int NCH = 4;
  localparam int AW  = 28;

  typedef struct packed {
    logic [AW-1:0] a;
    logic [31:0]   d;
    logic          w;
  } wr_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NCH*32-1:0] ctl_word = '0;
  logic [NCH*AW-1:0] prog_src = '0;
  logic [NCH*AW-1:0] prog_dst = '0;
  logic [NCH-1:0]    load_i = '0;
  logic [NCH-1:0]    arm_i = '0;
  logic              fifo_half_empty = 1'b0;
  logic              mem_valid;
  logic              mem_ready = 1'b0;
  logic              mem_we;
  logic              mem_word;
  logic [AW-1:0]     mem_addr;
  logic [31:0]       mem_wdata;
  logic [31:0]       mem_rdata = '0;
  logic              busy;
  logic [NCH-1:0]    irq_o;
  logic [NCH-1:0]    end_o;

  int    nchk = 0;
  int    nerr = 0;
  int    cyc  = 0;
  int    irq_cnt [NCH];
  int    end_cnt [NCH];
  bit    seen_busy = 1'b0;
  string cur_req = "R2";
  wr_t   exp_q [$];

  always #5 clk = ~clk;

  dma_xfer_engine #(.NCH(NCH), .AW(AW), .BURST(112)) uut (
    .clk (clk), .rst (rst), .ctl_word (ctl_word), .prog_src (prog_src),
    .prog_dst (prog_dst), .load_i (load_i), .arm_i (arm_i),
    .fifo_half_empty (fifo_half_empty), .mem_valid (mem_valid),
    .mem_ready (mem_ready), .mem_we (mem_we), .mem_word (mem_word),
    .mem_addr (mem_addr), .mem_wdata (mem_wdata), .mem_rdata (mem_rdata),
    .busy (busy), .irq_o (irq_o), .end_o (end_o)
  );

  function automatic logic [31:0] pat(input logic [AW-1:0] a);
    return {4'hC, a[15:0], a[27:16]};
  endfunction

  function automatic logic [AW-1:0] stp(input logic [AW-1:0] a, input logic [1:0] c,
                                        input bit is_dst, input bit w);
    logic [AW-1:0] s;
    s = w ? AW'(4) : AW'(2);
    if (c == 2'd0 || (is_dst && c == 2'd3)) return a + s;
    if (c == 2'd1) return a - s;
    return a;
  endfunction

  function automatic logic [31:0] mk(input int cnt, input logic [1:0] dc, input logic [1:0] sc,
                                     input bit rpt, input bit w, input logic [2:0] mode,
                                     input bit ie, input bit en);
    return {en, ie, mode, w, rpt, sc, dc, 21'(cnt)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // memory model and ready pattern
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_ready <= ((cyc % 5) != 3);
    if (mem_valid && mem_ready && !mem_we) mem_rdata <= pat(mem_addr);
  end

  // monitor: scoreboard pop and pulse counting
  always @(negedge clk) begin
    if (!rst) begin
      if (busy) seen_busy = 1'b1;
      for (int i = 0; i < NCH; i++) begin
        if (irq_o[i]) irq_cnt[i]++;
        if (end_o[i]) end_cnt[i]++;
      end
      if (mem_valid && mem_ready && mem_we) begin
        if (exp_q.size() == 0) begin
          check(1'b0, {cur_req, " unexpected write"}, {36'h0, mem_addr}, 64'h0);
        end else begin
          wr_t e;
          e = exp_q.pop_front();
          check(mem_addr == e.a, {cur_req, " write address"}, {36'h0, mem_addr}, {36'h0, e.a});
          check(mem_wdata == e.d && mem_word == e.w, {cur_req, " write data/size"},
                {31'h0, mem_word, mem_wdata}, {31'h0, e.w, e.d});
        end
      end
    end
  end

  task automatic prog(input int ch, input logic [31:0] c, input logic [AW-1:0] s, input logic [AW-1:0] d);
    @(negedge clk);
    ctl_word[ch*32 +: 32] = c;
    prog_src[ch*AW +: AW] = s;
    prog_dst[ch*AW +: AW] = d;
    load_i[ch] = 1'b1;
    @(negedge clk);
    load_i = '0;
  endtask

  task automatic arm(input logic [NCH-1:0] m);
    @(negedge clk);
    arm_i = m;
    @(negedge clk);
    arm_i = '0;
  endtask

  // driver: pushes the expected writes of one service
  task automatic push_run(input logic [AW-1:0] s, input logic [AW-1:0] d, input logic [1:0] sc,
                          input logic [1:0] dc, input bit w, input int n,
                          output logic [AW-1:0] s_end, output logic [AW-1:0] d_end);
    wr_t e;
    for (int i = 0; i < n; i++) begin
      e.a = d;
      e.d = w ? pat(s) : {16'h0, pat(s)[15:0]};
      e.w = w;
      exp_q.push_back(e);
      s = stp(s, sc, 1'b0, w);
      d = stp(d, dc, 1'b1, w);
    end
    s_end = s;
    d_end = d;
  endtask

  task automatic wait_idle();
    int q;
    q = 0;
    while (q < 4) begin
      @(negedge clk);
      if (!busy && !mem_valid) q++;
      else q = 0;
    end
  endtask

  task automatic drained(input string req);
    check(exp_q.size() == 0, {req, " all expected writes seen"}, 64'(exp_q.size()), 64'h0);
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [AW-1:0] se, de;
    int i0, e0;
    for (int i = 0; i < NCH; i++) begin irq_cnt[i] = 0; end_cnt[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check(busy == 1'b0, "R1 busy after reset", 64'(busy), 64'h0);
    check(mem_valid == 1'b0, "R1 mem_valid after reset", 64'(mem_valid), 64'h0);
    check(irq_o == '0, "R1 irq after reset", 64'(irq_o), 64'h0);
    check(end_o == '0, "R1 end after reset", 64'(end_o), 64'h0);

    // R2 R13 word copy, both increment, mode 0
    cur_req = "R2 R13";
    prog(0, mk(3, 2'd0, 2'd0, 0, 1, 3'd0, 0, 1), 28'h0001000, 28'h0002000);
    push_run(28'h0001000, 28'h0002000, 2'd0, 2'd0, 1'b1, 3, se, de);
    arm(4'b0001);
    wait_idle();
    drained("R2");
    check(end_cnt[0] == 1, "R9 end pulse mode 0", 64'(end_cnt[0]), 64'd1);
    check(irq_cnt[0] == 0, "R10 no irq when disabled", 64'(irq_cnt[0]), 64'd0);

    // R3 R4 R11 halfword, source decrement, destination fixed, irq
    cur_req = "R3 R4 R11";
    prog(1, mk(2, 2'd2, 2'd1, 0, 0, 3'd1, 1, 1), 28'h0003010, 28'h0004000);
    push_run(28'h0003010, 28'h0004000, 2'd1, 2'd2, 1'b0, 2, se, de);
    arm(4'b0010);
    wait_idle();
    drained("R3");
    check(irq_cnt[1] == 1, "R10 irq on completion", 64'(irq_cnt[1]), 64'd1);
    check(end_cnt[1] == 1, "R9 end without repeat", 64'(end_cnt[1]), 64'd1);

    // R6 ascending order on simultaneous arm
    cur_req = "R6";
    prog(2, mk(2, 2'd0, 2'd0, 0, 1, 3'd2, 0, 1), 28'h0005000, 28'h0006000);
    prog(1, mk(1, 2'd0, 2'd0, 0, 0, 3'd2, 0, 1), 28'h0007000, 28'h0007100);
    push_run(28'h0007000, 28'h0007100, 2'd0, 2'd0, 1'b0, 1, se, de);
    push_run(28'h0005000, 28'h0006000, 2'd0, 2'd0, 1'b1, 2, se, de);
    arm(4'b0110);
    wait_idle();
    drained("R6");

    // R8 repeat with destination reload
    cur_req = "R8";
    prog(3, mk(2, 2'd3, 2'd0, 1, 1, 3'd1, 1, 1), 28'h0008000, 28'h0009000);
    push_run(28'h0008000, 28'h0009000, 2'd0, 2'd3, 1'b1, 2, se, de);
    arm(4'b1000);
    wait_idle();
    drained("R8");
    check(end_cnt[3] == 0, "R8 no end on repeat", 64'(end_cnt[3]), 64'd0);
    check(irq_cnt[3] == 1, "R8 irq first round", 64'(irq_cnt[3]), 64'd1);
    push_run(28'h0008008, 28'h0009000, 2'd0, 2'd3, 1'b1, 2, se, de);
    arm(4'b1000);
    wait_idle();
    drained("R8");
    check(irq_cnt[3] == 2, "R8 irq second round", 64'(irq_cnt[3]), 64'd2);

    // R9 repeat bit ignored in mode 0
    cur_req = "R9";
    e0 = end_cnt[0];
    prog(0, mk(1, 2'd0, 2'd0, 1, 1, 3'd0, 0, 1), 28'h0001100, 28'h0001200);
    push_run(28'h0001100, 28'h0001200, 2'd0, 2'd0, 1'b1, 1, se, de);
    arm(4'b0001);
    wait_idle();
    drained("R9");
    check(end_cnt[0] == e0 + 1, "R9 mode 0 repeat ends", 64'(end_cnt[0]), 64'(e0 + 1));

    // R7 feed mode with flag high: two services, one completion
    cur_req = "R7";
    fifo_half_empty = 1'b1;
    i0 = irq_cnt[2];
    e0 = end_cnt[2];
    prog(2, mk(120, 2'd0, 2'd0, 0, 1, 3'd7, 1, 1), 28'h000A000, 28'h000B000);
    push_run(28'h000A000, 28'h000B000, 2'd0, 2'd0, 1'b1, 120, se, de);
    arm(4'b0100);
    wait_idle();
    fifo_half_empty = 1'b0;
    drained("R7");
    check(irq_cnt[2] == i0 + 1, "R7 single irq after drain", 64'(irq_cnt[2]), 64'(i0 + 1));
    check(end_cnt[2] == e0 + 1, "R7 single end after drain", 64'(end_cnt[2]), 64'(e0 + 1));

    // R7 feed mode with flag low: stops after 112 units
    i0 = irq_cnt[1];
    prog(1, mk(120, 2'd0, 2'd0, 0, 1, 3'd7, 1, 1), 28'h000E000, 28'h000F000);
    push_run(28'h000E000, 28'h000F000, 2'd0, 2'd0, 1'b1, 112, se, de);
    arm(4'b0010);
    wait_idle();
    drained("R7");
    check(irq_cnt[1] == i0, "R7 no irq with units left", 64'(irq_cnt[1]), 64'(i0));
    push_run(se, de, 2'd0, 2'd0, 1'b1, 8, se, de);
    arm(4'b0010);
    wait_idle();
    drained("R7");
    check(irq_cnt[1] == i0 + 1, "R7 irq after remainder", 64'(irq_cnt[1]), 64'(i0 + 1));

    // R3 R4 fixed source, decrementing destination, halfword
    cur_req = "R3 R4";
    prog(0, mk(3, 2'd1, 2'd2, 0, 0, 3'd1, 0, 1), 28'h000C000, 28'h000D004);
    push_run(28'h000C000, 28'h000D004, 2'd2, 2'd1, 1'b0, 3, se, de);
    arm(4'b0001);
    wait_idle();
    drained("R4");

    // R5 wrap in both directions
    cur_req = "R5";
    prog(3, mk(2, 2'd0, 2'd1, 0, 1, 3'd1, 0, 1), 28'h0000000, 28'hFFFFFFC);
    push_run(28'h0000000, 28'hFFFFFFC, 2'd1, 2'd0, 1'b1, 2, se, de);
    check(se == 28'hFFFFFF8 && de == 28'h0000004, "R5 model wrap", {8'h0, se, de}, {8'h0, 28'hFFFFFF8, 28'h0000004});
    arm(4'b1000);
    wait_idle();
    drained("R5");

    // R6 arm ignored while disabled
    cur_req = "R6";
    prog(2, mk(2, 2'd0, 2'd0, 0, 1, 3'd1, 1, 0), 28'h0001000, 28'h0002000);
    seen_busy = 1'b0;
    arm(4'b0100);
    repeat (12) @(negedge clk);
    check(seen_busy == 1'b0, "R6 disabled channel stays idle", 64'(seen_busy), 64'h0);
    drained("R6");

    // R12 zero count completes without access
    cur_req = "R12";
    i0 = irq_cnt[0];
    e0 = end_cnt[0];
    prog(0, mk(0, 2'd0, 2'd0, 0, 1, 3'd1, 1, 1), 28'h0001000, 28'h0002000);
    arm(4'b0001);
    wait_idle();
    drained("R12");
    check(irq_cnt[0] == i0 + 1, "R12 irq on empty service", 64'(irq_cnt[0]), 64'(i0 + 1));
    check(end_cnt[0] == e0 + 1, "R12 end on empty service", 64'(end_cnt[0]), 64'(e0 + 1));

    finish_up();
  end
endmodule